// File: doc/BRIEF.md
# Latched Byte Scan Sequencer with Cascade

This block takes a snapshot of a 32-bit count value and hands it out one byte at a time on an 8-bit shared bus. A host first pulses the active-low load strobe. This copies the count into a holding register and points the byte selector at the least significant byte. After that, every positive pulse on the scan strobe places the selected byte on the bus. Each falling edge of scan then moves the selector to the next more significant byte.

After the most significant byte, the selector parks in a terminal state. In that state the block releases the bus and pulls its active-low chain-enable output low. That output drives the enable input of the next block in a chain. Scan and load are shared by every block in the chain, so the devices put their bytes on the one bus in a fixed order, one device after another. Bus drive is modelled as a data bus plus an output-enable flag. All three control inputs are asynchronous and are resynchronised to the system clock inside the block.

Top module: `byte_scan_seq`

## Requirements
- R1: After reset, bus_oe_o is low, bus_o is zero and chain_en_no is high. The holding register is zero, and the selector points at byte 0 (bits 7:0).
- R2: While scan_load_ni is low, the holding register captures count_i and the selector returns to byte 0. A parked block also leaves its terminal state and raises chain_en_no again.
- R3: When enable_ni is low, each falling edge of scan_i moves the selector from byte n to byte n+1. Byte n is count bits 8n+7:8n.
- R4: A falling scan edge at byte 3 moves the selector to the terminal state. The block stays there until the next load, whatever scan does. While in that state chain_en_no is low and bus_oe_o is low.
- R5: bus_oe_o is high only while scan_i is high, enable_ni is low and the block is not parked. Whenever bus_oe_o is low, bus_o is zero.
- R6: While bus_oe_o is high, bus_o carries the byte of the holding register that the selector points at.
- R7: While enable_ni is high, falling scan edges leave the selector unchanged and bus_oe_o stays low.
- R8: When a load and a falling scan edge arrive in the same synchronised cycle, the load wins and the selector ends at byte 0.
- R9: Between loads, the holding register keeps its value however count_i changes.
- R10: When chain_en_no of one block drives enable_ni of a second block, with scan and load shared, the first block's four bytes appear on the bus, then the second block's four bytes.
- R11: A change on scan_i or enable_ni reaches bus_oe_o two clock edges later. A load reaches the selector, the holding register and chain_en_no three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 32 | Count value to snapshot |
| scan_i | input | 1 | Byte strobe; high presents a byte, a falling edge advances |
| scan_load_ni | input | 1 | Active-low load of the register and selector restart |
| enable_ni | input | 1 | Active-low enable |
| bus_o | output | 8 | Byte on the shared bus, zero when released |
| bus_oe_o | output | 1 | High while the block drives the bus |
| chain_en_no | output | 1 | Active-low enable for the next block in the chain |

## Verification
Each control input passes through two synchroniser flops. Bus drive therefore follows scan or enable after two clock edges. The selector, the holding register and the chain output need one more edge for the edge detect or the load. The bench drives inputs on falling clock edges and normally waits three falling edges before it samples, so every result has settled. A separate latency scenario samples one edge too early and then exactly on time, both for bus drive and for the recovery of the chain output after a load.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 4;

  function automatic int unsigned sel_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sync_cell.sv
module sync_cell #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int unsigned BYTES = scan_pkg::N_BYTES,
  localparam int unsigned SW = scan_pkg::sel_width(BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scan_s_i,
  input  logic          load_s_ni,
  input  logic          en_s_ni,
  output logic [SW-1:0] sel_o,
  output logic          parked_o,
  output logic          load_o
);
  localparam logic [SW-1:0] PARK = SW'(BYTES);

  logic          scan_q;
  logic          scan_fall;
  logic [SW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_q <= 1'b0;
    else         scan_q <= scan_s_i;
  end

  assign scan_fall = scan_q & ~scan_s_i;
  assign load_o    = ~load_s_ni;

  // load has priority over a step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   sel_q <= '0;
    else if (load_o)                               sel_q <= '0;
    else if (scan_fall && !en_s_ni && sel_q != PARK) sel_q <= sel_q + 1'b1;
  end

  assign sel_o    = sel_q;
  assign parked_o = (sel_q == PARK);

  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> sel_q == '0); // R2
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && scan_fall) |=> sel_q == '0); // R8
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_fall && !en_s_ni && !load_o && sel_q != PARK) |=> sel_q == $past(sel_q) + 1'b1); // R3
  AST_PARK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == PARK && !load_o) |=> sel_q == PARK); // R4
  AST_ENABLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s_ni && !load_o) |=> $stable(sel_q)); // R7
  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q <= PARK); // R4
endmodule

// File: rtl/snap_latch.sv
module snap_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= count_i;
  end

  assign snap_o = snap_q;

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> snap_q == $past(count_i)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(snap_q)); // R9
endmodule

// File: rtl/byte_drive.sv
module byte_drive #(
  parameter int unsigned BYTES = scan_pkg::N_BYTES,
  parameter int unsigned BW    = scan_pkg::BYTE_W,
  localparam int unsigned SW = scan_pkg::sel_width(BYTES),
  localparam int unsigned DW = BYTES * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] snap_i,
  input  logic [SW-1:0] sel_i,
  input  logic          parked_i,
  input  logic          scan_s_i,
  input  logic          en_s_ni,
  output logic [BW-1:0] bus_o,
  output logic          oe_o
);
  logic [BW-1:0] slice [BYTES];
  logic [BW-1:0] picked;

  for (genvar g = 0; g < BYTES; g++) begin : g_slice
    assign slice[g] = snap_i[g*BW +: BW];
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < BYTES; i++)
      if (sel_i == SW'(i)) picked = slice[i];
  end

  assign oe_o  = scan_s_i & ~en_s_ni & ~parked_i;
  assign bus_o = oe_o ? picked : '0;

  AST_RELEASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> bus_o == '0); // R5
  AST_NO_DRIVE_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_i |-> !oe_o); // R4
  AST_NO_DRIVE_LOW_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_s_i || en_s_ni) |-> !oe_o); // R7
endmodule

// File: rtl/byte_scan_seq.sv
module byte_scan_seq #(
  parameter int unsigned BYTES = scan_pkg::N_BYTES,
  parameter int unsigned BW    = scan_pkg::BYTE_W,
  localparam int unsigned SW = scan_pkg::sel_width(BYTES),
  localparam int unsigned DW = BYTES * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] count_i,
  input  logic          scan_i,
  input  logic          scan_load_ni,
  input  logic          enable_ni,
  output logic [BW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          chain_en_no
);
  logic [2:0]    ctl_s;
  logic          scan_s, load_s_n, en_s_n;
  logic [SW-1:0] sel;
  logic          parked, load;
  logic [DW-1:0] snap;

  // order: {scan, load_n, enable_n}; idle values on reset
  sync_cell #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scan_i, scan_load_ni, enable_ni}),
    .q_o   (ctl_s)
  );
  assign {scan_s, load_s_n, en_s_n} = ctl_s;

  scan_ctrl #(.BYTES(BYTES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scan_s_i (scan_s),
    .load_s_ni(load_s_n),
    .en_s_ni  (en_s_n),
    .sel_o    (sel),
    .parked_o (parked),
    .load_o   (load)
  );

  snap_latch #(.W(DW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .count_i(count_i),
    .snap_o (snap)
  );

  byte_drive #(.BYTES(BYTES), .BW(BW)) u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .snap_i  (snap),
    .sel_i   (sel),
    .parked_i(parked),
    .scan_s_i(scan_s),
    .en_s_ni (en_s_n),
    .bus_o   (bus_o),
    .oe_o    (bus_oe_o)
  );

  assign chain_en_no = ~parked;

  AST_CHAIN_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_en_no && load) |=> chain_en_no); // R2
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_en_no && !load) |=> !chain_en_no); // R4
endmodule

// File: tb/tb_byte_scan_seq.sv
module tb_byte_scan_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] count_a = '0, count_b = '0;
  logic        scan_i = 1'b0, scan_load_ni = 1'b1, en_a = 1'b1;
  logic [7:0]  bus_a, bus_b;
  logic        oe_a, oe_b, ce_a, ce_b;
  int          errors = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  byte_scan_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_a), .scan_i(scan_i),
    .scan_load_ni(scan_load_ni), .enable_ni(en_a),
    .bus_o(bus_a), .bus_oe_o(oe_a), .chain_en_no(ce_a)
  );

  byte_scan_seq dut_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_b), .scan_i(scan_i),
    .scan_load_ni(scan_load_ni), .enable_ni(ce_a),
    .bus_o(bus_b), .bus_oe_o(oe_b), .chain_en_no(ce_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic do_load(input logic [31:0] a, input logic [31:0] b);
    count_a = a; count_b = b;
    scan_load_ni = 1'b0; settle();
    scan_load_ni = 1'b1; settle();
  endtask

  // high phase: check drive, then falling edge
  task automatic scan_pulse(input string tag, input logic exp_oe, input logic [7:0] exp_bus);
    scan_i = 1'b1; settle();
    chk({tag, " oe"}, 32'(oe_a), 32'(exp_oe));
    chk({tag, " bus"}, 32'(bus_a), 32'(exp_bus));
    scan_i = 1'b0; settle();
    chk({tag, " released"}, 32'(oe_a), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 oe", 32'(oe_a), 32'd0);
    chk("R1 bus", 32'(bus_a), 32'd0);
    chk("R1 chain", 32'(ce_a), 32'd1);
    en_a = 1'b0; settle();
    scan_pulse("R1 zero byte0", 1'b1, 8'h00);
    do_load(32'h0, 32'h0);
  endtask

  task automatic t_sequence(input logic [31:0] v);
    do_load(v, 32'h0);
    for (int i = 0; i < 4; i++) scan_pulse("R3 R6 byte", 1'b1, v[i*8 +: 8]);
    chk("R4 chain low", 32'(ce_a), 32'd0);
    scan_pulse("R4 parked no drive", 1'b0, 8'h00);
    chk("R4 chain stays", 32'(ce_a), 32'd0);
    do_load(v, 32'h0);
    chk("R2 chain back", 32'(ce_a), 32'd1);
    scan_pulse("R2 restart byte0", 1'b1, v[7:0]);
  endtask

  task automatic t_enable();
    do_load(32'hA1B2C3D4, 32'h0);
    en_a = 1'b1; settle();
    scan_i = 1'b1; settle();
    chk("R7 R5 no drive when disabled", 32'(oe_a), 32'd0);
    chk("R5 bus zero", 32'(bus_a), 32'd0);
    scan_i = 1'b0; settle();
    scan_i = 1'b1; settle(); scan_i = 1'b0; settle();
    en_a = 1'b0; settle();
    scan_pulse("R7 still byte0", 1'b1, 8'hD4);
    scan_pulse("R7 then byte1", 1'b1, 8'hC3);
  endtask

  task automatic t_priority();
    do_load(32'h11223344, 32'h0);
    scan_i = 1'b1; settle();
    scan_i = 1'b0; scan_load_ni = 1'b0;   // same cycle in both synchronisers
    settle();
    scan_load_ni = 1'b1; settle();
    scan_pulse("R8 load wins", 1'b1, 8'h44);
  endtask

  task automatic t_hold();
    do_load(32'hCAFE0042, 32'h0);
    count_a = 32'h5555AAAA;
    repeat (5) @(negedge clk_i);
    count_a = 32'h01010101;
    scan_pulse("R9 hold b0", 1'b1, 8'h42);
    scan_pulse("R9 hold b1", 1'b1, 8'h00);
    scan_pulse("R9 hold b2", 1'b1, 8'hFE);
    scan_pulse("R9 hold b3", 1'b1, 8'hCA);
  endtask

  task automatic t_latency();
    do_load(32'h000000E7, 32'h0);
    scan_i = 1'b1;
    @(negedge clk_i);
    chk("R11 oe one edge early", 32'(oe_a), 32'd0);
    @(negedge clk_i);
    chk("R11 oe on time", 32'(oe_a), 32'd1);
    chk("R11 bus on time", 32'(bus_a), 32'hE7);
    scan_i = 1'b0; settle();
    for (int i = 0; i < 4; i++) begin
      scan_i = 1'b1; settle(); scan_i = 1'b0; settle();
    end
    chk("R11 parked", 32'(ce_a), 32'd0);
    scan_load_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R11 chain two edges", 32'(ce_a), 32'd0);
    @(negedge clk_i);
    chk("R11 chain three edges", 32'(ce_a), 32'd1);
    scan_load_ni = 1'b1; settle();
  endtask

  task automatic t_chain();
    logic [63:0] all;
    all = {32'h89ABCDEF, 32'h01234567};
    do_load(all[31:0], all[63:32]);
    for (int i = 0; i < 8; i++) begin
      scan_i = 1'b1; settle();
      chk("R10 one driver", 32'(oe_a) + 32'(oe_b), 32'd1);
      chk("R10 bus byte", 32'(oe_a ? bus_a : bus_b), 32'(all[i*8 +: 8]));
      scan_i = 1'b0; settle();
    end
    chk("R10 b parked", 32'(ce_b), 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sequence(32'h12345678);
    t_sequence(32'hFF00A55A);
    t_enable();
    t_priority();
    t_hold();
    t_latency();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule